// File: doc/BRIEF.md
# Activity-Based Clock Frequency Governor

This block picks a clock rate, in kHz, for a monitored clock domain from how busy that domain has been. Once per measurement period a sampler reports how many cycles the domain sat idle. The governor turns this into a count of active cycles. It keeps a running sum of the last 128 such counts and divides the sum by the window length in milliseconds to get an average frequency. A tracked "bumped" frequency follows that average inside a hysteresis band and then gets 12.5% headroom added. A boost term grows geometrically while the domain stays busy and decays geometrically while it is idle. The sum of the bumped frequency and the boost is rounded up to the nearest entry of a fixed table of allowed rates. The block only proposes a rate. Switching the clock is left to other logic.

After reset the block spends 128 cycles seeding the window as if the domain had been fully busy at the minimum rate. It then accepts samples. Each accepted sample runs through a bit-serial divider, and the new target appears with a one-cycle valid pulse.

Top module: `actfreq_governor`

## Requirements
- R1: After reset release the block spends exactly 128 clock cycles filling every window entry with (period+1)×min_rate. During that time sample_valid is ignored and target_valid stays low. At the end the bumped frequency is min_rate, the boost is zero and the sample count is zero. During reset target_rate and target_valid are 0. period and min_rate must be held steady during the fill.
- R2: The active count of a sample is (period+1)×cur_rate − idle_cycles, or 0 when idle_cycles is larger.
- R3: The window holds 128 entries. Each accepted active count replaces the oldest entry, and the running sum is adjusted by the difference. The average is floor(sum / ((period+1)×128)), where period is the value held at the end of the fill.
- R4: If idle ≥ 1 + (active >> 3) and the previous bumped value ≥ the new average, the boost becomes (boost×128) >> 8. It is set to 0 when that result is below 1000.
- R5: In every other case the sample count is first incremented. If the incremented count is below 3, the boost is unchanged and the count is incremented once more.
- R6: In the remaining case the boost becomes ((boost×511) >> 8) + 1000, limited to max_rate.
- R7: If average + 1000 < bumped, bumped becomes average + 1000. Otherwise, if average > bumped + 1000, bumped becomes average − 1000. After that step, bumped gains bumped >> 3.
- R8: The target is max(bumped, min_rate) + boost, rounded up to the smallest allowed rate that is at least that value. Values above 300000 give 300000. The allowed rates in kHz are 40000, 48000, 50000, 60000, 75000, 80000, 100000, 120000, 150000, 200000, 240000 and 300000.
- R9: A sample is accepted on a clock edge where sample_valid is high and the block is idle. target_valid is then high for exactly one cycle, following the edge RATE_W+PERIOD_W+1+LOG2_WIN+1 edges after acceptance (41 with default parameters). target_rate holds its value until the next result.
- R10: A sample presented while the block is filling or computing has no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Idle sample strobe |
| idle_cycles | input | RATE_W+PERIOD_W+1 | Idle cycles counted in the last period |
| cur_rate | input | RATE_W | Current clock rate in kHz |
| min_rate | input | RATE_W | Lowest permitted rate in kHz |
| max_rate | input | RATE_W | Ceiling for the boost term in kHz |
| period | input | PERIOD_W | Sample period in ms, minus one |
| target_rate | output | RATE_W | Proposed rate in kHz |
| target_valid | output | 1 | One-cycle pulse when target_rate is new |

## Verification
The hardest situation to reach from the ports is the boost decay branch. It needs a large boost together with a bumped value that sits above the new average. The stimulus first drives long runs of fully busy samples at the top rate, which pushes the boost to its cap and the average upward. It then switches to samples whose idle count exceeds the period's cycles, so the active count floors at zero. Samples that arrive during the fill and in the middle of a computation, including a stretch where sample_valid is held high continuously, show that dropped samples leave no trace in later targets.

// File: rtl/gov_pkg.sv
package gov_pkg;
  typedef logic [63:0] wide_t;
  typedef enum logic [1:0] {ST_FILL, ST_IDLE, ST_DIV} gov_state_e;

  localparam wide_t BOOST_STEP  = 64'd1000;
  localparam wide_t BAND        = 64'd1000;
  localparam wide_t INC_COEF    = 64'd255;
  localparam wide_t DEC_COEF    = 64'd128;
  localparam int    FRAC_BITS   = 8;
  localparam int    MIN_SAMPLES = 3;
  localparam int    N_RATES     = 12;

  // allowed rates in kHz, index 0 is the highest
  function automatic wide_t rate_at(input int idx);
    case (idx)
      0: return 64'd300000;  1: return 64'd240000;  2: return 64'd200000;
      3: return 64'd150000;  4: return 64'd120000;  5: return 64'd100000;
      6: return 64'd80000;   7: return 64'd75000;   8: return 64'd60000;
      9: return 64'd50000;   10: return 64'd48000;  default: return 64'd40000;
    endcase
  endfunction

  function automatic wide_t f_active(input wide_t per, input wide_t rate, input wide_t idle);
    wide_t full = (per + 64'd1) * rate;
    return (full > idle) ? full - idle : 64'd0;
  endfunction

  function automatic wide_t f_decay(input wide_t b);
    wide_t r = (b * ((64'd1 << FRAC_BITS) - DEC_COEF)) >> FRAC_BITS;
    return (r < BOOST_STEP) ? 64'd0 : r;
  endfunction

  function automatic wide_t f_grow(input wide_t b, input wide_t cap);
    wide_t r = ((b * ((64'd1 << FRAC_BITS) + INC_COEF)) >> FRAC_BITS) + BOOST_STEP;
    return (r > cap) ? cap : r;
  endfunction

  function automatic wide_t f_hyst(input wide_t b, input wide_t avg);
    wide_t r = b;
    if (avg + BAND < b) r = avg + BAND;
    else if (avg > b + BAND) r = avg - BAND;
    return r + (r >> 3);
  endfunction

  // smallest table entry not below x; top entry when x is above all
  function automatic wide_t f_snap(input wide_t x);
    wide_t r = rate_at(0);
    for (int i = 1; i < N_RATES; i++)
      if (rate_at(i) >= x) r = rate_at(i);
    return r;
  endfunction

  function automatic logic f_is_rate(input wide_t x);
    logic hit = 1'b0;
    for (int i = 0; i < N_RATES; i++)
      if (rate_at(i) == x) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/gov_window.sv
module gov_window #(
  parameter int DATA_W     = 33,
  parameter int LOG2_DEPTH = 7,
  parameter int SUM_W      = DATA_W + LOG2_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              fill,
  input  logic [DATA_W-1:0] wdata,
  output logic [SUM_W-1:0]  sum_next
);
  localparam int DEPTH = 1 << LOG2_DEPTH;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [LOG2_DEPTH-1:0] ptr;
  logic [SUM_W-1:0]      sum_q;

  always_comb begin
    if (!we)       sum_next = sum_q;
    else if (fill) sum_next = sum_q + SUM_W'(wdata);
    else           sum_next = sum_q - SUM_W'(mem[ptr]) + SUM_W'(wdata);
  end

  always_ff @(posedge clk) begin
    if (we) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      sum_q <= '0;
    end else begin
      sum_q <= sum_next;
      if (we) ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/gov_divider.sv
module gov_divider #(
  parameter int N_W = 40,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quotient,
  output logic           done
);
  localparam int CNT_W = $clog2(N_W);

  logic [N_W-1:0]   dvd_q;
  logic [D_W-1:0]   rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [D_W:0]     rem_sh;
  logic             q_bit;
  logic [D_W-1:0]   rem_step;

  always_comb begin
    rem_sh   = {rem_q, dvd_q[N_W-1]};
    q_bit    = (rem_sh >= {1'b0, divisor});
    rem_step = q_bit ? D_W'(rem_sh - {1'b0, divisor}) : D_W'(rem_sh);
  end

  assign quotient = dvd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd_q  <= dividend;
        rem_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_step;
        dvd_q <= {dvd_q[N_W-2:0], q_bit};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(N_W - 1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gov_policy.sv
module gov_policy
  import gov_pkg::*;
#(
  parameter int CNT_W  = 33,
  parameter int RATE_W = 24,
  parameter int CW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              upd,
  input  logic [RATE_W-1:0] min_rate,
  input  logic [RATE_W-1:0] max_rate,
  input  logic [CNT_W-1:0]  avg,
  input  logic [CNT_W-1:0]  act,
  input  logic [CNT_W-1:0]  idle,
  output logic [RATE_W-1:0] target,
  output logic              target_valid,
  output logic [CNT_W-1:0]  boost_o,
  output logic              decay_ev,
  output logic              grow_ev
);
  logic [CNT_W-1:0] bump_q, boost_q;
  logic [CW-1:0]    cnt_q, cnt_new;
  logic             decay_c, warm_c;
  wide_t            boost_w, bump_w, floor_w, tgt_w;

  always_comb begin
    cnt_new = (cnt_q >= CW'(MIN_SAMPLES)) ? cnt_q : cnt_q + 1'b1;
    decay_c = (wide_t'(idle) >= 64'd1 + (wide_t'(act) >> 3)) && (bump_q >= avg);
    warm_c  = !decay_c && (cnt_new < CW'(MIN_SAMPLES));
    if (decay_c)     boost_w = f_decay(wide_t'(boost_q));
    else if (warm_c) boost_w = wide_t'(boost_q);
    else             boost_w = f_grow(wide_t'(boost_q), wide_t'(max_rate));
    bump_w  = f_hyst(wide_t'(bump_q), wide_t'(avg));
    floor_w = (bump_w > wide_t'(min_rate)) ? bump_w : wide_t'(min_rate);
    tgt_w   = f_snap(floor_w + boost_w);
  end

  assign decay_ev = upd && decay_c;
  assign grow_ev  = upd && !decay_c && !warm_c;
  assign boost_o  = boost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bump_q       <= '0;
      boost_q      <= '0;
      cnt_q        <= '0;
      target       <= '0;
      target_valid <= 1'b0;
    end else begin
      target_valid <= upd;
      if (load) begin
        bump_q  <= CNT_W'(min_rate);
        boost_q <= '0;
        cnt_q   <= '0;
      end else if (upd) begin
        bump_q  <= CNT_W'(bump_w);
        boost_q <= CNT_W'(boost_w);
        cnt_q   <= warm_c ? cnt_new + 1'b1 : cnt_new;
        target  <= RATE_W'(tgt_w);
      end
    end
  end
endmodule

// File: rtl/actfreq_governor.sv
module actfreq_governor
  import gov_pkg::*;
#(
  parameter int RATE_W   = 24,
  parameter int PERIOD_W = 8,
  parameter int LOG2_WIN = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_valid,
  input  logic [RATE_W+PERIOD_W:0]   idle_cycles,
  input  logic [RATE_W-1:0]          cur_rate,
  input  logic [RATE_W-1:0]          min_rate,
  input  logic [RATE_W-1:0]          max_rate,
  input  logic [PERIOD_W-1:0]        period,
  output logic [RATE_W-1:0]          target_rate,
  output logic                       target_valid
);
  localparam int CNT_W = RATE_W + PERIOD_W + 1;
  localparam int SUM_W = CNT_W + LOG2_WIN;
  localparam int DIV_W = PERIOD_W + 1 + LOG2_WIN;
  localparam int CW    = $clog2(MIN_SAMPLES + 1);

  gov_state_e          st_q;
  logic [LOG2_WIN-1:0] fill_idx;
  logic [CNT_W-1:0]    act_now, fill_val, wdata, act_q, idle_q;
  logic [DIV_W-1:0]    win_len;
  logic [SUM_W-1:0]    sum_next, quot;
  logic [CNT_W-1:0]    boost_val;

  // named events for the checker
  logic in_fill, in_div, fill_last, accept_ev, div_done, decay_ev, grow_ev;

  assign in_fill   = (st_q == ST_FILL);
  assign in_div    = (st_q == ST_DIV);
  assign fill_last = in_fill && (fill_idx == '1);
  assign accept_ev = (st_q == ST_IDLE) && sample_valid;

  assign act_now  = CNT_W'(f_active(wide_t'(period), wide_t'(cur_rate), wide_t'(idle_cycles)));
  assign fill_val = CNT_W'(f_active(wide_t'(period), wide_t'(min_rate), 64'd0));
  assign wdata    = in_fill ? fill_val : act_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_FILL;
      fill_idx <= '0;
      act_q    <= '0;
      idle_q   <= '0;
      win_len  <= '0;
    end else begin
      case (st_q)
        ST_FILL: begin
          fill_idx <= fill_idx + 1'b1;
          if (fill_last) begin
            win_len <= DIV_W'((wide_t'(period) + 64'd1) << LOG2_WIN);
            st_q    <= ST_IDLE;
          end
        end
        ST_IDLE: if (accept_ev) begin
          act_q  <= act_now;
          idle_q <= idle_cycles;
          st_q   <= ST_DIV;
        end
        default: if (div_done) st_q <= ST_IDLE;
      endcase
    end
  end

  gov_window #(.DATA_W(CNT_W), .LOG2_DEPTH(LOG2_WIN), .SUM_W(SUM_W)) u_window (
    .clk(clk), .rst_n(rst_n), .we(in_fill || accept_ev), .fill(in_fill),
    .wdata(wdata), .sum_next(sum_next)
  );

  gov_divider #(.N_W(SUM_W), .D_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept_ev), .dividend(sum_next),
    .divisor(win_len), .quotient(quot), .done(div_done)
  );

  gov_policy #(.CNT_W(CNT_W), .RATE_W(RATE_W), .CW(CW)) u_policy (
    .clk(clk), .rst_n(rst_n), .load(fill_last), .upd(div_done),
    .min_rate(min_rate), .max_rate(max_rate), .avg(CNT_W'(quot)),
    .act(act_q), .idle(idle_q), .target(target_rate),
    .target_valid(target_valid), .boost_o(boost_val),
    .decay_ev(decay_ev), .grow_ev(grow_ev)
  );
endmodule

// File: rtl/gov_chk.sv
module gov_chk #(
  parameter int RATE_W = 24,
  parameter int CNT_W  = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              target_valid,
  input logic [RATE_W-1:0] target_rate,
  input logic [RATE_W-1:0] max_rate,
  input logic              in_fill,
  input logic              in_div,
  input logic              accept_ev,
  input logic              div_done,
  input logic [CNT_W-1:0]  boost_val,
  input logic              decay_ev,
  input logic              grow_ev
);
  // R1
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> (!target_valid && !accept_ev));
  // R9
  valid_after_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_valid |-> $past(div_done));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_valid |=> !target_valid);
  // R8
  target_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_valid |-> gov_pkg::f_is_rate(gov_pkg::wide_t'(target_rate)));
  // R10
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (in_div && !accept_ev));
  // R6
  boost_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grow_ev |=> (boost_val <= CNT_W'($past(max_rate))));
  // R4
  boost_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decay_ev |=> (boost_val <= $past(boost_val)));
endmodule

bind actfreq_governor gov_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .target_valid(target_valid),
  .target_rate(target_rate), .max_rate(max_rate), .in_fill(in_fill),
  .in_div(in_div), .accept_ev(accept_ev), .div_done(div_done),
  .boost_val(boost_val), .decay_ev(decay_ev), .grow_ev(grow_ev)
);

// File: tb/tb_actfreq_governor.sv
module tb_actfreq_governor;
  localparam int RATE_W = 24, PERIOD_W = 8, LOG2_WIN = 7;
  localparam int CNT_W = RATE_W + PERIOD_W + 1;
  localparam int WIN = 1 << LOG2_WIN;
  localparam int LAT = CNT_W + LOG2_WIN + 1;

  logic clk = 0, rst_n = 0, sample_valid = 0;
  logic [CNT_W-1:0] idle_cycles = '0;
  logic [RATE_W-1:0] cur_rate = 24'd40000, min_rate = 24'd40000, max_rate = 24'd300000;
  logic [PERIOD_W-1:0] period = 8'd9;
  logic [RATE_W-1:0] target_rate;
  logic target_valid;

  actfreq_governor #(.RATE_W(RATE_W), .PERIOD_W(PERIOD_W), .LOG2_WIN(LOG2_WIN)) dut (.*);

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference model
  longint win_q[$];
  longint m_sum, m_wlen, m_bump, m_boost, m_act, m_idle, exp_tgt;
  int m_cnt, fill_left, busy_left;
  bit exp_valid;
  string note, tag;
  int rates[12] = '{40000, 48000, 50000, 60000, 75000, 80000, 100000, 120000,
                    150000, 200000, 240000, 300000};

  function automatic longint round_up(longint x);
    longint best = 300000;
    foreach (rates[i]) if (rates[i] >= x && rates[i] < best) best = rates[i];
    return best;
  endfunction

  task automatic model_result();
    longint avg, nb;
    avg = m_sum / m_wlen;
    m_cnt++;
    if (m_idle >= 1 + m_act / 8 && m_bump >= avg) begin
      m_boost = m_boost * 128 / 256;
      if (m_boost < 1000) m_boost = 0;
      tag = "R4";
    end else if (m_cnt < 3) begin
      m_cnt++;
      tag = "R5";
    end else begin
      m_boost = m_boost * 511 / 256 + 1000;
      if (m_boost > max_rate) m_boost = max_rate;
      tag = "R6";
    end
    if (avg + 1000 < m_bump) m_bump = avg + 1000;
    else if (avg > m_bump + 1000) m_bump = avg - 1000;
    m_bump = m_bump + m_bump / 8;
    nb = (m_bump > min_rate) ? m_bump : min_rate;
    exp_tgt = round_up(nb + m_boost);
    tag = {tag, " R2 R3 R7 R8", note};
    note = "";
    exp_valid = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      fill_left = WIN; busy_left = 0; exp_valid = 0; exp_tgt = 0;
      note = ""; tag = "R1"; win_q.delete();
    end else begin
      exp_valid = 0;
      if (fill_left > 0) begin
        if (sample_valid) note = {note, " R1"};
        fill_left--;
        if (fill_left == 0) begin
          for (int i = 0; i < WIN; i++) win_q.push_back((period + 1) * longint'(min_rate));
          m_sum = 0;
          foreach (win_q[i]) m_sum += win_q[i];
          m_wlen = (period + 1) * WIN;
          m_bump = min_rate; m_boost = 0; m_cnt = 0;
        end
      end else if (busy_left > 0) begin
        if (sample_valid) note = {note, " R10"};
        busy_left--;
        if (busy_left == 0) model_result();
      end else if (sample_valid) begin
        longint full;
        full = (period + 1) * longint'(cur_rate);
        m_act = (full > longint'(idle_cycles)) ? full - longint'(idle_cycles) : 0;
        m_idle = idle_cycles;
        m_sum = m_sum - win_q.pop_front() + m_act;
        win_q.push_back(m_act);
        busy_left = LAT;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(target_valid === exp_valid, fill_left > 0 ? "R1 valid" : "R9 valid timing",
            target_valid, exp_valid);
      check(target_rate === RATE_W'(exp_tgt), exp_valid ? tag : "R9 hold",
            target_rate, exp_tgt);
    end
  end

  task automatic send(longint idl, int rate);
    @(negedge clk);
    sample_valid = 1; idle_cycles = CNT_W'(idl); cur_rate = RATE_W'(rate);
    @(negedge clk);
    sample_valid = 0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(target_rate === '0 && target_valid === 1'b0, "R1 reset", target_rate, 0);
    rst_n = 1;
    // samples during the fill are dropped (R1)
    repeat (40) @(negedge clk);
    sample_valid = 1; idle_cycles = '0; cur_rate = 24'd300000;
    @(negedge clk); sample_valid = 0;
    repeat (100) @(negedge clk);
    // warm-up and mid activity (R5)
    send(200000, 40000);
    send(100000, 60000);
    // fully busy at top rate: boost grows to the cap, clamp to 300000 (R6, R8)
    for (int k = 0; k < 12; k++) send(0, 300000);
    // idle exceeds the period's cycles: active floors at zero, boost decays (R2, R4)
    for (int k = 0; k < 20; k++) send(5000000, 40000);
    // mixed activity
    for (int k = 0; k < 60; k++) begin
      int r;
      r = rates[(k * 5) % 12];
      send((longint'(k) * 37717) % (10 * longint'(r)), r);
    end
    // sample in the middle of a computation is dropped (R10)
    @(negedge clk); sample_valid = 1; idle_cycles = 33'd1000; cur_rate = 24'd150000;
    @(negedge clk); sample_valid = 0;
    repeat (10) @(negedge clk);
    sample_valid = 1; idle_cycles = '0; cur_rate = 24'd300000;
    @(negedge clk); sample_valid = 0;
    repeat (LAT + 5) @(negedge clk);
    // strobe held high: accepted only when idle (R9, R10)
    for (int k = 0; k < 400; k++) begin
      sample_valid = 1;
      idle_cycles = CNT_W'((longint'(k) * 7919) % 3000000);
      cur_rate = RATE_W'(rates[k % 12]);
      @(negedge clk);
    end
    sample_valid = 0;
    repeat (LAT + 5) @(negedge clk);
    finish_run();
  end
endmodule